// File: doc/BRIEF.md
# Event Handshake Sequencer

This block is the master side of an event loop that links one trigger source to a group of worker readout units. When it accepts a trigger it closes the trigger gate at once. It then sends a command word and an event tag toward the digitizer. After that it sends the same tag on a broadcast bus, so that every worker knows which event it is about to handle.

It then waits until each worker has acknowledged the current event. An acknowledge counts only if the tag the worker returns equals the current tag. When the last acknowledge arrives, the gate opens again.

Triggers that come in while the gate is closed are not acted on, but they are counted. A wait that lasts longer than a programmable number of cycles ends in an error state. In that state the block reports which workers did not answer, and the gate stays closed until an explicit clear arrives.

Top module: `evl_loop_master`

## Requirements
- R1: After reset, `trig_en` is 1, `cmd_valid`, `bcast_valid`, `tag_err` and `err_timeout` are 0, and `drop_count` is 0.
- R2: A trigger is accepted when `trig_in` is 1 in a cycle where `trig_en` is 1. From the next cycle `trig_en` is 0, and it stays 0 until the event closes.
- R3: In the cycle after acceptance, `cmd_valid` is 1 for exactly one cycle. `cmd_word` equals the `cmd_code` sampled at acceptance, and `cmd_tag` carries the event tag.
- R4: The first event after reset has tag 0. Each accepted trigger adds one to the tag, and the tag wraps to 0 modulo 2^TAGW.
- R5: In the cycle after `cmd_valid`, `bcast_valid` is 1 for exactly one cycle, and `bcast_tag` equals the event tag.
- R6: From the cycle after the broadcast, the block waits for acknowledges. An acknowledge from worker i is recorded when `ack_vld[i]` is 1 and `ack_tag[i*TAGW +: TAGW]` equals the event tag. A recorded acknowledge stays set until the next event. Several workers may acknowledge in the same cycle.
- R7: `trig_en` returns to 1 in the cycle after the clock edge on which the last outstanding worker is recorded, and not earlier.
- R8: An acknowledge whose tag differs from the event tag does not record that worker. In that case `tag_err` is 1 for the following cycle.
- R9: While `trig_en` is 0, `trig_in` has no effect on the sequence or on the tag. Each such cycle adds one to `drop_count`.
- R10: When `timeout_limit` is nonzero and the wait has lasted `timeout_limit` cycles without all acknowledges, `err_timeout` becomes 1. At the same time `err_missing` shows a 1 for each worker that was not recorded, and `trig_en` stays 0.
- R11: Asserting `err_clr` while `err_timeout` is 1 returns the block to idle. `trig_en` is 1 and `err_missing` is 0 in the next cycle.
- R12: A `timeout_limit` of 0 disables the timeout, so the wait lasts until all workers have acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Event trigger, one per cycle high |
| cmd_code | input | CMDW | Command word to issue with the next event |
| timeout_limit | input | TOW | Acknowledge wait limit in cycles, 0 disables |
| err_clr | input | 1 | Leaves the timeout error state |
| trig_en | output | 1 | Trigger gate, 1 while a trigger can be accepted |
| cmd_valid | output | 1 | Command strobe toward the digitizer |
| cmd_word | output | CMDW | Command word of the current event |
| cmd_tag | output | TAGW | Event tag toward the digitizer |
| bcast_valid | output | 1 | Broadcast strobe toward all workers |
| bcast_tag | output | TAGW | Event tag on the broadcast bus |
| ack_vld | input | NWORK | Per-worker acknowledge strobe |
| ack_tag | input | NWORK*TAGW | Per-worker returned tag, worker i in bits i*TAGW and up |
| tag_err | output | 1 | One-cycle flag for an acknowledge with a wrong tag |
| err_timeout | output | 1 | Wait timed out, block halted |
| err_missing | output | NWORK | Workers not recorded at timeout |
| drop_count | output | DROPW | Count of triggers arriving while the gate is closed |

## Verification
The assertions check the following on every cycle:
- the gate closes right after an acceptance, and the command strobe follows;
- the broadcast strobe follows the command strobe one cycle later and carries the same tag;
- the gate and the strobes are never active together;
- the drop counter steps on each refused trigger;
- the gate stays closed while the timeout error is set.

Some properties need a sequence of stimulus over several events, and only the bench scenarios show them:
- the gate reopens on exactly the last matching acknowledge;
- a worker that returns a wrong tag still counts as missing;
- the reported missing-worker mask is correct;
- a limit of 0 disables the timeout;
- the tag wraps across many events.

// File: rtl/evl_pkg.sv
// Shared types for the event handshake sequencer.
package evl_pkg;

    // Sequencer states: idle gate open, command, broadcast, ack wait, halted
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_BCAST,
        ST_WAIT,
        ST_ERR
    } evl_state_e;

endpackage

// File: rtl/evl_ack_gather.sv
// Collects per-worker acknowledges for the current event.
// Assumes: clr is pulsed before the wait starts; en is high only while the
// sequencer waits. Worker i returns its tag in ack_tag[i*TAGW +: TAGW].
module evl_ack_gather #(
    parameter int NWORK = 4,
    parameter int TAGW  = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  en,
    input  logic [NWORK-1:0]      ack_vld,
    input  logic [NWORK*TAGW-1:0] ack_tag,
    input  logic [TAGW-1:0]       cur_tag,
    output logic [NWORK-1:0]      got_next,
    output logic                  all_done,
    output logic                  mismatch
);

    logic [NWORK-1:0] got_q;
    logic [NWORK-1:0] hit;
    logic [NWORK-1:0] miss;

    // One tag comparator per worker
    for (genvar i = 0; i < NWORK; i++) begin : g_worker
        logic same;
        assign same    = (ack_tag[i*TAGW +: TAGW] == cur_tag);
        assign hit[i]  = en && ack_vld[i] && same;
        assign miss[i] = en && ack_vld[i] && !same;
    end

    // Combine sticky state with this cycle's matching acknowledges
    always_comb begin
        got_next = got_q | hit;
        all_done = en && (&got_next);
        mismatch = |miss;
    end

    // Sticky per-worker record, cleared per event
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            got_q <= '0;
        end else if (en) begin
            got_q <= got_next;
        end
    end

endmodule

// File: rtl/evl_wait_timer.sv
// Counts cycles spent waiting for acknowledges and flags expiry.
// Assumes: run stays high for the whole wait; limit of 0 means no expiry.
module evl_wait_timer #(
    parameter int TOW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [TOW-1:0] limit,
    output logic           expired
);

    logic [TOW-1:0] cnt;

    // Cycle counter, held at zero outside the wait
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + TOW'(1);
        end
    end

    // Expiry on the last permitted wait cycle
    always_comb begin
        expired = run && (limit != '0) && (cnt == limit - TOW'(1));
    end

endmodule

// File: rtl/evl_loop_master.sv
// Event handshake sequencer: gates triggers, issues command and tag,
// broadcasts the tag to workers, waits for all matching acknowledges.
// Assumes: one trigger per high cycle of trig_in; NWORK from 1 to 16.
module evl_loop_master
    import evl_pkg::*;
#(
    parameter int NWORK = 4,
    parameter int TAGW  = 24,
    parameter int CMDW  = 8,
    parameter int TOW   = 16,
    parameter int DROPW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig_in,
    input  logic [CMDW-1:0]       cmd_code,
    input  logic [TOW-1:0]        timeout_limit,
    input  logic                  err_clr,
    output logic                  trig_en,
    output logic                  cmd_valid,
    output logic [CMDW-1:0]       cmd_word,
    output logic [TAGW-1:0]       cmd_tag,
    output logic                  bcast_valid,
    output logic [TAGW-1:0]       bcast_tag,
    input  logic [NWORK-1:0]      ack_vld,
    input  logic [NWORK*TAGW-1:0] ack_tag,
    output logic                  tag_err,
    output logic                  err_timeout,
    output logic [NWORK-1:0]      err_missing,
    output logic [DROPW-1:0]      drop_count
);

    evl_state_e       state;
    logic [TAGW-1:0]  cur_tag;
    logic [TAGW-1:0]  next_tag;
    logic [CMDW-1:0]  cmd_q;
    logic [NWORK-1:0] got_next;
    logic             all_done;
    logic             mismatch;
    logic             expired;
    logic             waiting;

    // Decode outputs from the state
    always_comb begin
        trig_en     = (state == ST_IDLE);
        cmd_valid   = (state == ST_CMD);
        bcast_valid = (state == ST_BCAST);
        err_timeout = (state == ST_ERR);
        waiting     = (state == ST_WAIT);
        cmd_word    = cmd_q;
        cmd_tag     = cur_tag;
        bcast_tag   = cur_tag;
    end

    evl_ack_gather #(
        .NWORK(NWORK),
        .TAGW (TAGW)
    ) u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (bcast_valid),
        .en      (waiting),
        .ack_vld (ack_vld),
        .ack_tag (ack_tag),
        .cur_tag (cur_tag),
        .got_next(got_next),
        .all_done(all_done),
        .mismatch(mismatch)
    );

    evl_wait_timer #(
        .TOW(TOW)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (waiting),
        .limit  (timeout_limit),
        .expired(expired)
    );

    // Main sequence: accept, command, broadcast, wait, close or halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cur_tag     <= '0;
            next_tag    <= '0;
            cmd_q       <= '0;
            err_missing <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (trig_in) begin
                        state    <= ST_CMD;
                        cur_tag  <= next_tag;
                        next_tag <= next_tag + TAGW'(1);
                        cmd_q    <= cmd_code;
                    end
                end
                ST_CMD:   state <= ST_BCAST;
                ST_BCAST: state <= ST_WAIT;
                ST_WAIT: begin
                    if (all_done) begin
                        state <= ST_IDLE;
                    end else if (expired) begin
                        state       <= ST_ERR;
                        err_missing <= ~got_next;
                    end
                end
                ST_ERR: begin
                    if (err_clr) begin
                        state       <= ST_IDLE;
                        err_missing <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Refused-trigger counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_count <= '0;
        end else if (trig_in && !trig_en) begin
            drop_count <= drop_count + DROPW'(1);
        end
    end

    // One-cycle wrong-tag flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_err <= 1'b0;
        end else begin
            tag_err <= mismatch;
        end
    end

endmodule

// File: rtl/evl_loop_chk.sv
// Port-level protocol checks for the event handshake sequencer.
// Assumes: attached by bind, observing the top module's ports only.
module evl_loop_chk #(
    parameter int TAGW  = 24,
    parameter int DROPW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_in,
    input logic             trig_en,
    input logic             cmd_valid,
    input logic             bcast_valid,
    input logic [TAGW-1:0]  cmd_tag,
    input logic [TAGW-1:0]  bcast_tag,
    input logic             err_timeout,
    input logic [DROPW-1:0] drop_count
);

    // R2
    gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && trig_en) |=> !trig_en);

    // R3
    cmd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && trig_en) |=> cmd_valid);

    // R5
    bcast_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (bcast_valid && bcast_tag == $past(cmd_tag)));

    // R2
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trig_en, cmd_valid, bcast_valid, err_timeout}));

    // R9
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && !trig_en) |=> (drop_count == $past(drop_count) + DROPW'(1)));

    // R10
    halt_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timeout && !$rose(err_timeout)) |-> $past(!trig_en));

endmodule

bind evl_loop_master evl_loop_chk #(
    .TAGW (TAGW),
    .DROPW(DROPW)
) u_loop_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_in    (trig_in),
    .trig_en    (trig_en),
    .cmd_valid  (cmd_valid),
    .bcast_valid(bcast_valid),
    .cmd_tag    (cmd_tag),
    .bcast_tag  (bcast_tag),
    .err_timeout(err_timeout),
    .drop_count (drop_count)
);

// File: tb/test_evl_loop_master.sv
// Directed bench for the event handshake sequencer.
module test_evl_loop_master;

    localparam int NW = 4;
    localparam int TW = 4;
    localparam int CW = 8;
    localparam int OW = 16;
    localparam int DW = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             trig_in;
    logic [CW-1:0]    cmd_code;
    logic [OW-1:0]    timeout_limit;
    logic             err_clr;
    logic             trig_en;
    logic             cmd_valid;
    logic [CW-1:0]    cmd_word;
    logic [TW-1:0]    cmd_tag;
    logic             bcast_valid;
    logic [TW-1:0]    bcast_tag;
    logic [NW-1:0]    ack_vld;
    logic [NW*TW-1:0] ack_tag;
    logic             tag_err;
    logic             err_timeout;
    logic [NW-1:0]    err_missing;
    logic [DW-1:0]    drop_count;

    int n_cmp = 0;
    int n_bad = 0;
    logic [TW-1:0] exp_tag = '0;

    always #10 clk = ~clk;

    evl_loop_master #(
        .NWORK(NW), .TAGW(TW), .CMDW(CW), .TOW(OW), .DROPW(DW)
    ) i_evl_loop_master (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cmd_code(cmd_code),
        .timeout_limit(timeout_limit), .err_clr(err_clr), .trig_en(trig_en),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_tag(cmd_tag),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .ack_vld(ack_vld),
        .ack_tag(ack_tag), .tag_err(tag_err), .err_timeout(err_timeout),
        .err_missing(err_missing), .drop_count(drop_count)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Accept a trigger and walk through command and broadcast
    task automatic start_event(input logic [CW-1:0] code);
        trig_in  = 1'b1;
        cmd_code = code;
        step();
        trig_in  = 1'b0;
        cmd_code = '0;
        chk("R2 gate closed", trig_en, 0);
        chk("R3 cmd_valid", cmd_valid, 1);
        chk("R3 cmd_word", cmd_word, code);
        chk("R4 cmd_tag", cmd_tag, exp_tag);
        step();
        chk("R3 cmd single", cmd_valid, 0);
        chk("R5 bcast_valid", bcast_valid, 1);
        chk("R5 bcast_tag", bcast_tag, exp_tag);
        step();
        chk("R5 bcast single", bcast_valid, 0);
    endtask

    // Present acknowledges for one cycle, all returning the given tag
    task automatic send_ack(input logic [NW-1:0] mask, input logic [TW-1:0] tg);
        ack_vld = mask;
        for (int i = 0; i < NW; i++) ack_tag[i*TW +: TW] = tg;
        step();
        ack_vld = '0;
        ack_tag = '0;
    endtask

    task automatic t_reset();
        chk("R1 trig_en", trig_en, 1);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 bcast_valid", bcast_valid, 0);
        chk("R1 tag_err", tag_err, 0);
        chk("R1 err_timeout", err_timeout, 0);
        chk("R1 drop_count", drop_count, 0);
    endtask

    // Workers answer one by one, gate reopens only after the last
    task automatic t_serial_acks();
        start_event(8'hA5);
        send_ack(4'b0100, exp_tag);
        chk("R7 early", trig_en, 0);
        send_ack(4'b0001, exp_tag);
        chk("R7 early", trig_en, 0);
        send_ack(4'b1000, exp_tag);
        chk("R7 early", trig_en, 0);
        step();
        chk("R6 sticky wait", trig_en, 0);
        send_ack(4'b0010, exp_tag);
        chk("R7 reopen", trig_en, 1);
        exp_tag++;
    endtask

    // All workers answer in the same cycle
    task automatic t_joint_acks();
        start_event(8'h3C);
        send_ack(4'b1111, exp_tag);
        chk("R6 joint ack reopen", trig_en, 1);
        exp_tag++;
    endtask

    // A wrong tag does not count and raises the flag
    task automatic t_wrong_tag();
        start_event(8'h11);
        send_ack(4'b0010, exp_tag ^ 4'h1);
        chk("R8 tag_err", tag_err, 1);
        send_ack(4'b1101, exp_tag);
        chk("R8 tag_err single", tag_err, 0);
        chk("R8 worker not recorded", trig_en, 0);
        send_ack(4'b0010, exp_tag);
        chk("R8 reopen after good ack", trig_en, 1);
        exp_tag++;
    endtask

    // Triggers while the gate is closed are counted and ignored
    task automatic t_drop();
        logic [DW-1:0] d0;
        d0 = drop_count;
        start_event(8'h22);
        trig_in = 1'b1;
        step();
        step();
        trig_in = 1'b0;
        chk("R9 drop_count", drop_count, d0 + 2);
        chk("R9 no command", cmd_valid, 0);
        chk("R9 gate closed", trig_en, 0);
        send_ack(4'b1111, exp_tag);
        chk("R9 reopen", trig_en, 1);
        exp_tag++;
        start_event(8'h23);
        send_ack(4'b1111, exp_tag);
        exp_tag++;
    endtask

    // Timeout reports missing workers, halts, then clears
    task automatic t_timeout();
        logic [DW-1:0] d0;
        timeout_limit = 16'd20;
        start_event(8'h44);
        send_ack(4'b0001, exp_tag);
        send_ack(4'b0100, exp_tag);
        repeat (17) step();
        chk("R10 not yet", err_timeout, 0);
        step();
        chk("R10 err_timeout", err_timeout, 1);
        chk("R10 err_missing", err_missing, 4'b1010);
        chk("R10 gate closed", trig_en, 0);
        d0 = drop_count;
        trig_in = 1'b1;
        step();
        trig_in = 1'b0;
        chk("R10 halted", err_timeout, 1);
        chk("R9 drop in error", drop_count, d0 + 1);
        err_clr = 1'b1;
        step();
        err_clr = 1'b0;
        chk("R11 gate reopen", trig_en, 1);
        chk("R11 mask cleared", err_missing, 0);
        exp_tag++;
    endtask

    // Limit of zero never times out
    task automatic t_no_limit();
        timeout_limit = '0;
        start_event(8'h55);
        repeat (60) step();
        chk("R12 no timeout", err_timeout, 0);
        chk("R12 still waiting", trig_en, 0);
        send_ack(4'b1111, exp_tag);
        chk("R12 reopen", trig_en, 1);
        exp_tag++;
        timeout_limit = 16'd20;
    endtask

    // Run events until the tag wraps to zero
    task automatic t_wrap();
        for (int k = 0; k < 18; k++) begin
            start_event(CW'(k));
            send_ack(4'b1111, exp_tag);
            chk("R4 event closes", trig_en, 1);
            exp_tag++;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        trig_in = 1'b0;
        cmd_code = '0;
        timeout_limit = 16'd20;
        err_clr = 1'b0;
        ack_vld = '0;
        ack_tag = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_serial_acks();
        t_joint_acks();
        t_wrong_tag();
        t_drop();
        t_timeout();
        t_no_limit();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule